// File: doc/BRIEF.md
# Floating-Point NaN Result Fixup Stage

This block sits behind a two-operand floating-point arithmetic unit and settles what its result should be when that result is a NaN. It receives the raw arithmetic result and both source operands as bit patterns, together with a precision select (single or double) and a mode bit that forces the canonical NaN. A raw result that is not a NaN leaves the block unchanged. A NaN result is replaced by a NaN chosen from a fixed ranking: the canonical quiet NaN, a signalling operand converted to quiet, or a quiet operand copied through. Signalling operands always outrank quiet ones, and the first operand outranks the second.

The block also raises an invalid-operation flag whenever either operand is a signalling NaN. The selection logic is purely combinational. A parameter adds an optional output register stage, which costs one cycle of latency and carries a valid bit alongside the data.

Top module: `fpnan_fix`

## Requirements
- R1: When the raw result is not a NaN, the output equals the raw result. In double mode all 64 bits are copied. In single mode the low 32 bits are copied and the upper 32 bits are zero. An infinity (exponent all ones, fraction zero) counts as not a NaN.
- R2: A value is a NaN when its exponent field is all ones and its fraction is nonzero. In single mode the exponent is bits 30:23 and the fraction is bits 22:0. In double mode the exponent is bits 62:52 and the fraction is bits 51:0. A NaN is quiet when the fraction MSB (bit 22 in single mode, bit 51 in double mode) is 1, and signalling otherwise.
- R3: When the raw result is a NaN and neither operand is a NaN, the output is the canonical quiet NaN: 0x7FC00000 in single mode and 0x7FF8000000000000 in double mode.
- R4: With the default-NaN mode bit set to 1, every NaN result becomes the canonical quiet NaN of the selected format, whatever the operand payloads.
- R5: Otherwise, a signalling first operand wins. The output is that operand ORed with the canonical quiet-NaN pattern, which keeps its sign and payload. This holds even when the second operand is also signalling.
- R6: Next in rank, a signalling second operand is quieted in the same way. This applies when the first operand is not signalling.
- R7: When neither operand is signalling, a quiet first operand is copied unchanged. If the first operand is not a NaN, a quiet second operand is copied unchanged.
- R8: In single mode the upper 32 bits of the raw result and of both operands have no effect on the output or on the flag.
- R9: The invalid flag is 1 exactly when either operand is a signalling NaN in the selected format. This holds in default-NaN mode and when the raw result is not a NaN.
- R10: With the output register enabled (the default), the output valid bit equals the input valid bit from one cycle earlier, and the data and flag reflect the inputs of that accepted cycle. When the input valid bit is low, the data and flag hold their previous values. During reset, the output valid bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Inputs on this cycle are to be processed |
| fmt_dbl | input | 1 | 1 = double precision, 0 = single precision |
| dflt_nan_mode | input | 1 | 1 = every NaN result becomes the canonical quiet NaN |
| raw_res | input | 64 | Raw result from the arithmetic unit |
| op_a | input | 64 | First source operand |
| op_b | input | 64 | Second source operand |
| out_valid | output | 1 | Output data and flag are valid |
| out_res | output | 64 | Fixed-up result |
| out_invalid | output | 1 | Invalid-operation flag (a signalling operand was seen) |

## Verification
With the default register stage, every result and flag is due exactly one clock after the cycle in which `in_valid` was sampled high. The valid bit is due on that same edge, for every cycle.

The bench drives inputs on the falling edge and computes the expected result from its own model at that moment. It then compares the outputs on the next falling edge, after the single register stage has updated. On cycles with no accepted input, it checks that the data and flag still hold the last accepted result.

// File: rtl/fpnan_pkg.sv
package fpnan_pkg;
  localparam int SP_EXP_W  = 8;
  localparam int SP_FRAC_W = 23;
  localparam int DP_EXP_W  = 11;
  localparam int DP_FRAC_W = 52;
  localparam int SP_W      = 1 + SP_EXP_W + SP_FRAC_W;
  localparam int DP_W      = 1 + DP_EXP_W + DP_FRAC_W;

  localparam logic [DP_W-1:0] SP_QNAN =
    DP_W'({1'b0, {SP_EXP_W{1'b1}}, 1'b1, {(SP_FRAC_W-1){1'b0}}});
  localparam logic [DP_W-1:0] DP_QNAN =
    {1'b0, {DP_EXP_W{1'b1}}, 1'b1, {(DP_FRAC_W-1){1'b0}}};
  localparam logic [DP_W-1:0] SP_LANE = DP_W'({SP_W{1'b1}});
  localparam logic [DP_W-1:0] DP_LANE = {DP_W{1'b1}};

  typedef struct packed {
    logic is_nan;
    logic is_snan;
  } fpnan_cls_t;

  typedef enum logic [2:0] {
    PICK_RAW,
    PICK_DFLT,
    PICK_QUIET_A,
    PICK_QUIET_B,
    PICK_PASS_A,
    PICK_PASS_B
  } fpnan_pick_t;
endpackage

// File: rtl/fpnan_classify.sv
module fpnan_classify
  import fpnan_pkg::*;
(
  input  logic [DP_W-1:0] value_i,
  input  logic            dbl_i,
  output fpnan_cls_t      cls_o
);
  logic            sp_exp_ones;
  logic            sp_frac_nz;
  logic            dp_exp_ones;
  logic            dp_frac_nz;
  logic            nan;
  logic            quiet;
  logic [DP_W-1:0] qmask;

  always_comb begin
    sp_exp_ones = &value_i[SP_FRAC_W +: SP_EXP_W];
    sp_frac_nz  = |value_i[SP_FRAC_W-1:0];
    dp_exp_ones = &value_i[DP_FRAC_W +: DP_EXP_W];
    dp_frac_nz  = |value_i[DP_FRAC_W-1:0];
    qmask       = dbl_i ? DP_QNAN : SP_QNAN;
    nan         = dbl_i ? (dp_exp_ones && dp_frac_nz)
                        : (sp_exp_ones && sp_frac_nz);
    // quiet when every bit of the canonical pattern is present
    quiet         = ((value_i & qmask) == qmask);
    cls_o.is_nan  = nan;
    cls_o.is_snan = nan && !quiet;
  end
endmodule

// File: rtl/fpnan_select.sv
module fpnan_select
  import fpnan_pkg::*;
(
  input  logic            dbl_i,
  input  logic            dn_i,
  input  logic [DP_W-1:0] raw_i,
  input  logic [DP_W-1:0] a_i,
  input  logic [DP_W-1:0] b_i,
  input  fpnan_cls_t      raw_cls_i,
  input  fpnan_cls_t      a_cls_i,
  input  fpnan_cls_t      b_cls_i,
  output logic [DP_W-1:0] res_o,
  output logic            invalid_o,
  output fpnan_pick_t     pick_o
);
  logic [DP_W-1:0] qmask;
  logic [DP_W-1:0] lane;
  logic [DP_W-1:0] chosen;

  // ranking: default, signalling A, signalling B, quiet A, quiet B
  always_comb begin
    if (!raw_cls_i.is_nan)                              pick_o = PICK_RAW;
    else if (dn_i || (!a_cls_i.is_nan && !b_cls_i.is_nan)) pick_o = PICK_DFLT;
    else if (a_cls_i.is_snan)                           pick_o = PICK_QUIET_A;
    else if (b_cls_i.is_snan)                           pick_o = PICK_QUIET_B;
    else if (a_cls_i.is_nan)                            pick_o = PICK_PASS_A;
    else                                                pick_o = PICK_PASS_B;
  end

  always_comb begin
    qmask = dbl_i ? DP_QNAN : SP_QNAN;
    lane  = dbl_i ? DP_LANE : SP_LANE;
    unique case (pick_o)
      PICK_DFLT:    chosen = qmask;
      PICK_QUIET_A: chosen = a_i | qmask;
      PICK_QUIET_B: chosen = b_i | qmask;
      PICK_PASS_A:  chosen = a_i;
      PICK_PASS_B:  chosen = b_i;
      default:      chosen = raw_i;
    endcase
    res_o     = chosen & lane;
    invalid_o = a_cls_i.is_snan | b_cls_i.is_snan;
  end
endmodule

// File: rtl/fpnan_outstage.sv
module fpnan_outstage
  import fpnan_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            valid_i,
  input  logic [DP_W-1:0] res_i,
  input  logic            inv_i,
  output logic            valid_o,
  output logic [DP_W-1:0] res_o,
  output logic            inv_o
);
  generate
    if (OUT_REG) begin : g_reg
      logic            valid_d, valid_q;
      logic [DP_W-1:0] res_d, res_q;
      logic            inv_d, inv_q;

      always_comb begin
        valid_d = valid_i;
        res_d   = res_q;
        inv_d   = inv_q;
        if (valid_i) begin
          res_d = res_i;
          inv_d = inv_i;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          valid_q <= 1'b0;
          res_q   <= '0;
          inv_q   <= 1'b0;
        end else begin
          valid_q <= valid_d;
          res_q   <= res_d;
          inv_q   <= inv_d;
        end
      end

      assign valid_o = valid_q;
      assign res_o   = res_q;
      assign inv_o   = inv_q;

      assert_valid_delay_R10: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |=> valid_o);
      assert_valid_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> !valid_o);
      assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> ($stable(res_o) && $stable(inv_o)));
    end else begin : g_bypass
      assign valid_o = valid_i;
      assign res_o   = res_i;
      assign inv_o   = inv_i;
    end
  endgenerate
endmodule

// File: rtl/fpnan_fix.sv
module fpnan_fix
  import fpnan_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic        fmt_dbl,
  input  logic        dflt_nan_mode,
  input  logic [63:0] raw_res,
  input  logic [63:0] op_a,
  input  logic [63:0] op_b,
  output logic        out_valid,
  output logic [63:0] out_res,
  output logic        out_invalid
);
  localparam int N_VAL = 3;

  logic [DP_W-1:0] vals [N_VAL];
  fpnan_cls_t      cls  [N_VAL];
  logic [DP_W-1:0] sel_res;
  logic            sel_inv;
  fpnan_pick_t     pick;

  assign vals[0] = raw_res;
  assign vals[1] = op_a;
  assign vals[2] = op_b;

  generate
    for (genvar i = 0; i < N_VAL; i++) begin : g_cls
      fpnan_classify u_cls (
        .value_i (vals[i]),
        .dbl_i   (fmt_dbl),
        .cls_o   (cls[i])
      );
    end
  endgenerate

  fpnan_select u_sel (
    .dbl_i     (fmt_dbl),
    .dn_i      (dflt_nan_mode),
    .raw_i     (raw_res),
    .a_i       (op_a),
    .b_i       (op_b),
    .raw_cls_i (cls[0]),
    .a_cls_i   (cls[1]),
    .b_cls_i   (cls[2]),
    .res_o     (sel_res),
    .invalid_o (sel_inv),
    .pick_o    (pick)
  );

  fpnan_outstage #(.OUT_REG(OUT_REG)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .valid_i (in_valid),
    .res_i   (sel_res),
    .inv_i   (sel_inv),
    .valid_o (out_valid),
    .res_o   (out_res),
    .inv_o   (out_invalid)
  );

  assert_passthru_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && fmt_dbl && !cls[0].is_nan) |-> (sel_res == raw_res));
  assert_sp_upper_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !fmt_dbl) |-> (sel_res[63:32] == 32'h0));
  assert_dflt_canon_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && dflt_nan_mode && cls[0].is_nan)
      |-> (sel_res == (fmt_dbl ? DP_QNAN : SP_QNAN)));
  assert_nan_out_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && fmt_dbl && cls[0].is_nan) |-> (&sel_res[62:51]));
  assert_no_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !cls[1].is_nan && !cls[2].is_nan) |-> !sel_inv);
  assert_pick_raw_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cls[0].is_nan) |-> (pick != PICK_RAW));
endmodule

// File: tb/tb_fpnan_fix.sv
module tb_fpnan_fix;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        fmt_dbl = 1'b0;
  logic        dflt_nan_mode = 1'b0;
  logic [63:0] raw_res = '0;
  logic [63:0] op_a = '0;
  logic [63:0] op_b = '0;
  logic        out_valid;
  logic [63:0] out_res;
  logic        out_invalid;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  bit          pend_valid = 0;
  bit [63:0]   pend_res = '0;
  bit          pend_inv = 0;
  string       pend_tag = "R10";
  bit          have_last = 0;
  bit [63:0]   last_res = '0;
  bit          last_inv = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fpnan_fix dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .fmt_dbl(fmt_dbl),
    .dflt_nan_mode(dflt_nan_mode), .raw_res(raw_res), .op_a(op_a),
    .op_b(op_b), .out_valid(out_valid), .out_res(out_res),
    .out_invalid(out_invalid)
  );

  function automatic bit m_nan(bit dbl, bit [63:0] x);
    if (dbl) return (x[62:52] == 11'h7FF) && (x[51:0] != 0);
    return (x[30:23] == 8'hFF) && (x[22:0] != 0);
  endfunction

  function automatic bit m_snan(bit dbl, bit [63:0] x);
    return m_nan(dbl, x) && !(dbl ? x[51] : x[22]);
  endfunction

  task automatic model(input bit dbl, input bit dn, input bit [63:0] raw,
                       input bit [63:0] a, input bit [63:0] b,
                       output bit [63:0] r, output bit inv);
    bit [63:0] q;
    bit [63:0] rr, aa, bb;
    q  = dbl ? 64'h7FF8000000000000 : 64'h0000_0000_7FC00000;
    rr = dbl ? raw : {32'h0, raw[31:0]};
    aa = dbl ? a : {32'h0, a[31:0]};
    bb = dbl ? b : {32'h0, b[31:0]};
    inv = m_snan(dbl, aa) || m_snan(dbl, bb);
    if (!m_nan(dbl, rr)) r = rr;
    else if (dn) r = q;
    else if (!m_nan(dbl, aa) && !m_nan(dbl, bb)) r = q;
    else if (m_snan(dbl, aa)) r = aa | q;
    else if (m_snan(dbl, bb)) r = bb | q;
    else if (m_nan(dbl, aa)) r = aa;
    else r = bb;
  endtask

  task automatic check_outputs();
    checks++;
    if (out_valid !== pend_valid) begin
      errors++;
      $display("FAIL R10 out_valid actual %0b expected %0b", out_valid, pend_valid);
    end
    if (pend_valid) begin
      checks++;
      if (out_res !== pend_res || out_invalid !== pend_inv) begin
        errors++;
        $display("FAIL %s res/inv actual %h/%0b expected %h/%0b",
                 pend_tag, out_res, out_invalid, pend_res, pend_inv);
      end
      have_last = 1; last_res = pend_res; last_inv = pend_inv;
    end else if (have_last) begin
      checks++;
      if (out_res !== last_res || out_invalid !== last_inv) begin
        errors++;
        $display("FAIL R10 hold actual %h/%0b expected %h/%0b",
                 out_res, out_invalid, last_res, last_inv);
      end
    end
  endtask

  task automatic step(input bit v, input bit dbl, input bit dn,
                      input bit [63:0] raw, input bit [63:0] a,
                      input bit [63:0] b, input string tag);
    bit [63:0] r;
    bit inv;
    @(negedge clk);
    check_outputs();
    in_valid = v; fmt_dbl = dbl; dflt_nan_mode = dn;
    raw_res = raw; op_a = a; op_b = b;
    model(dbl, dn, raw, a, b, r, inv);
    pend_valid = v; pend_res = r; pend_inv = inv; pend_tag = tag;
  endtask

  function automatic bit [63:0] rnd_val(bit dbl);
    int k;
    bit [63:0] p;
    k = $urandom_range(0, 3);
    p = {$urandom, $urandom};
    if (dbl) begin
      case (k)
        0: return p;
        1: return {p[63], 11'h7FF, 52'h0};
        2: return {p[63], 11'h7FF, 1'b1, p[50:0]};
        default: return {p[63], 11'h7FF, 1'b0, p[50:1], 1'b1};
      endcase
    end else begin
      case (k)
        0: return p;
        1: return {p[63:32], p[31], 8'hFF, 23'h0};
        2: return {p[63:32], p[31], 8'hFF, 1'b1, p[21:0]};
        default: return {p[63:32], p[31], 8'hFF, 1'b0, p[21:1], 1'b1};
      endcase
    end
  endfunction

  localparam bit [63:0] D_ONE  = 64'h3FF0000000000000;
  localparam bit [63:0] D_INF  = 64'h7FF0000000000000;
  localparam bit [63:0] D_QN   = 64'h7FF8000000000000;
  localparam bit [63:0] D_SNA  = 64'hFFF0000000000001;
  localparam bit [63:0] D_SNB  = 64'h7FF0000000ABCDEF;
  localparam bit [63:0] D_QNA  = 64'hFFF8000000001234;
  localparam bit [63:0] D_QNB  = 64'h7FFC000000005678;

  initial begin
    for (int i = 0; i < 3; i++) step(0, 0, 0, '0, '0, '0, "R10 reset");
    @(negedge clk);
    check_outputs();
    rst_n = 1'b1;
    step(1, 1, 0, D_ONE, D_ONE, D_ONE, "R1 double number");
    step(1, 0, 0, 64'hDEADBEEF_3F800000, '0, '0, "R1 R8 single number");
    step(1, 1, 0, D_INF, D_SNA, D_ONE, "R1 R2 R9 infinity not NaN, flag set");
    step(1, 1, 0, D_QN, D_ONE, D_INF, "R3 double canonical");
    step(1, 0, 0, 64'h0000_0000_FFC00001, 64'h3F800000, 64'h7F800000, "R3 single canonical");
    step(1, 1, 1, D_QN, D_SNA, D_QNB, "R4 R9 default mode");
    step(1, 0, 1, 64'h7FC00000, 64'h7FA00001, 64'h7FC00009, "R4 single default mode");
    step(1, 1, 0, D_QN, D_SNA, D_SNB, "R5 signalling A beats signalling B");
    step(1, 1, 0, D_QN, D_QNA, D_SNB, "R6 signalling B beats quiet A");
    step(1, 0, 0, 64'h7FC00000, 64'h7FC00011, 64'hFF800123, "R6 single signalling B");
    step(1, 1, 0, D_QN, D_QNA, D_QNB, "R7 quiet A first");
    step(1, 1, 0, D_QN, D_ONE, D_QNB, "R7 quiet B when A numeric");
    step(1, 0, 0, 64'h7FC00000, 64'h7FC00000_7FC00077, 64'h3F800000, "R7 R8 single quiet A");
    step(1, 0, 0, 64'h7FF00000_3F800000, 64'h7FF00001_00000000, 64'h7FF00001_40000000, "R8 upper halves ignored");
    step(1, 0, 0, 64'h7FC00000, 64'h7FF00001_00000000, 64'h7F800001, "R2 R8 single sNaN B, A upper bits ignored");
    step(0, 1, 0, D_QN, D_SNA, D_SNB, "R10 idle holds");
    step(0, 0, 1, '0, '0, '0, "R10 idle holds");
    step(1, 1, 0, D_QN, D_QNB, D_SNA, "R6 R10 after gap");
    for (int i = 0; i < 400; i++) begin
      bit dbl;
      bit [63:0] rv;
      dbl = $urandom_range(0, 1);
      rv = ($urandom_range(0, 3) == 0) ? rnd_val(dbl) : (dbl ? D_QN : {$urandom, 32'h7FC00000});
      step($urandom_range(0, 4) != 0, dbl, $urandom_range(0, 5) == 0, rv,
           rnd_val(dbl), rnd_val(dbl), "R5 R6 R7 R9 random");
    end
    step(0, 0, 0, '0, '0, '0, "R10 drain");
    @(negedge clk);
    check_outputs();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL R10 watchdog expired actual hung expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule